// File: doc/BRIEF.md
# ROM Patch Substitution Unit

This block sits in the read path between a processor and an on-chip ROM. It lets software replace faulty ROM content without touching the ROM array. Several correction channels each hold a window address and eight replacement bytes. When a fetch falls inside an enabled window and correction is switched on globally, the corrected word goes back to the processor in place of the raw ROM word. The swap is combinational and adds no wait state.

Software programs the unit over a simple register bus. It first sets the global register write-enable, which is the only state in which channel registers take writes. It then loads each channel's window address, enable flag and 64-bit patch data. Finally it writes the control value that turns correction on and closes register writes. To reprogram a unit that is already correcting, software must first reset the control register and then open writes again.

Top module: `rom_patch_unit`

## Requirements
- R1: After reset the control register, every channel address register and every channel data register read 0. Every fetch returns rom_data_i unchanged.
- R2: The control register sits at offset 0x00 and accepts writes at all times. Bit 0 is the register write-enable, bit 2 is the correction enable and bit 3 is a mode flag that is stored and read back. All other bits read 0, so writing 0xFF reads back 0x0D.
- R3: The channel registers change only on writes made while control bit 0 is 1. With control at 0x00 or 0x04, writes to them leave both the readback values and the fetch results unchanged.
- R4: The address register of channel k sits at offset 0x40+0x10*k. It stores the window address in bits 19..0 and the channel enable in bit 31, and bits 30..20 read 0.
- R5: The 64-bit data register of channel k reads and writes as two words: bits 31..0 at offset 0x44+0x10*k and bits 63..32 at offset 0x48+0x10*k. Readback does not depend on the write-enable.
- R6: A fetch is substituted only when control bit 2 is 1 and the enable bit of a matching channel is 1. Otherwise the raw ROM word passes through.
- R7: A channel matches when fetch address bits 19..3 equal its stored bits 19..3. Stored bits 2..0 and fetch bits 31..20 do not take part, so each window is the aligned 8-byte block that holds the programmed address.
- R8: Byte lanes are little-endian. Byte offset b of the block (b = 0..7) comes from data bits 8b+7..8b. On the 32-bit read port, fetch address bit 2 picks data bits 31..0 (0) or 63..32 (1).
- R9: When more than one enabled channel matches, the lowest-numbered one supplies the data.
- R10: Substitution is combinational. fetch_data_o reflects fetch_addr_i and rom_data_i in the same cycle, with no added latency. It equals rom_data_i whenever no channel matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register readback for reg_addr_i (combinational) |
| fetch_addr_i | input | 32 | Fetch byte address from the processor |
| rom_data_i | input | 32 | Raw word from the ROM for fetch_addr_i |
| fetch_data_o | output | 32 | Word returned to the processor, patched or raw |

## Verification
The assertions assume that the register bus and the fetch port are driven with defined values and change only away from the rising clock edge. They also assume that rom_data_i is the ROM word for the fetch address presented in the same cycle. The bench changes every input on the falling edge and derives rom_data_i arithmetically from fetch_addr_i, so a pass-through can always be told apart from a patch. Sweeps cover every word around each window, both with and without high address bits set.

// File: rtl/rpu_pkg.sv
package rpu_pkg;
  localparam int REG_W         = 32;
  localparam int CTRL_WEN_BIT  = 0;
  localparam int CTRL_CEN_BIT  = 2;
  localparam int CTRL_MODE_BIT = 3;
  localparam int CH_EN_BIT     = 31;

  localparam int CTRL_OFS      = 'h00;
  localparam int CH_BASE       = 'h40;
  localparam int CH_STRIDE     = 'h10;
  localparam int CH_DATA_OFS   = 'h04;
  localparam int WORD_BYTES    = REG_W / 8;

  function automatic int ch_addr_ofs(int k);
    return CH_BASE + k * CH_STRIDE;
  endfunction

  function automatic int ch_data_ofs(int k, int w);
    return CH_BASE + k * CH_STRIDE + CH_DATA_OFS + w * WORD_BYTES;
  endfunction
endpackage

// File: rtl/rpu_regs.sv
module rpu_regs
  import rpu_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int MATCH_AW = 20,
  parameter int PATCH_W  = 64,
  parameter int REG_AW   = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               reg_wr_i,
  input  logic [REG_AW-1:0]                  reg_addr_i,
  input  logic [REG_W-1:0]                   reg_wdata_i,
  output logic [REG_W-1:0]                   reg_rdata_o,
  output logic                               corr_en_o,
  output logic [NUM_CH-1:0]                  ch_en_o,
  output logic [NUM_CH-1:0][MATCH_AW-1:0]    ch_addr_o,
  output logic [NUM_CH-1:0][PATCH_W-1:0]     ch_data_o
);
  localparam int DWORDS = PATCH_W / REG_W;

  logic wen_q, cen_q, mode_q;
  logic ctrl_sel;
  logic [NUM_CH-1:0]             addr_hit;
  logic [NUM_CH-1:0][DWORDS-1:0] data_hit;

  assign ctrl_sel  = (reg_addr_i == REG_AW'(CTRL_OFS));
  assign corr_en_o = cen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q  <= 1'b0;
      cen_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (reg_wr_i && ctrl_sel) begin
      wen_q  <= reg_wdata_i[CTRL_WEN_BIT];
      cen_q  <= reg_wdata_i[CTRL_CEN_BIT];
      mode_q <= reg_wdata_i[CTRL_MODE_BIT];
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic                          en_q;
    logic [MATCH_AW-1:0]           addr_q;
    logic [DWORDS-1:0][REG_W-1:0]  data_q;

    assign addr_hit[k] = (reg_addr_i == REG_AW'(ch_addr_ofs(k)));
    for (genvar w = 0; w < DWORDS; w++) begin : g_hit
      assign data_hit[k][w] = (reg_addr_i == REG_AW'(ch_data_ofs(k, w)));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        addr_q <= '0;
        data_q <= '0;
      end else if (reg_wr_i && wen_q) begin
        if (addr_hit[k]) begin
          en_q   <= reg_wdata_i[CH_EN_BIT];
          addr_q <= reg_wdata_i[MATCH_AW-1:0];
        end
        for (int w = 0; w < DWORDS; w++) begin
          if (data_hit[k][w]) data_q[w] <= reg_wdata_i;
        end
      end
    end

    assign ch_en_o[k]   = en_q;
    assign ch_addr_o[k] = addr_q;
    assign ch_data_o[k] = data_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (ctrl_sel) begin
      reg_rdata_o[CTRL_WEN_BIT]  = wen_q;
      reg_rdata_o[CTRL_CEN_BIT]  = cen_q;
      reg_rdata_o[CTRL_MODE_BIT] = mode_q;
    end
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr_hit[k]) begin
        reg_rdata_o[CH_EN_BIT]      = ch_en_o[k];
        reg_rdata_o[MATCH_AW-1:0]   = ch_addr_o[k];
      end
      for (int w = 0; w < DWORDS; w++) begin
        if (data_hit[k][w]) reg_rdata_o = ch_data_o[k][w*REG_W +: REG_W];
      end
    end
  end

  // Channel state is frozen unless writes were open
  assert_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |=> ($stable(ch_en_o) && $stable(ch_addr_o) && $stable(ch_data_o)));

  // Correction enable moves only on a control write
  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && ctrl_sel) |=> $stable(corr_en_o));
endmodule

// File: rtl/rpu_match.sv
module rpu_match #(
  parameter int NUM_CH   = 4,
  parameter int MATCH_AW = 20,
  parameter int BLK_LOG2 = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [MATCH_AW-1:0]             fetch_addr_i,
  input  logic                            corr_en_i,
  input  logic [NUM_CH-1:0]               ch_en_i,
  input  logic [NUM_CH-1:0][MATCH_AW-1:0] ch_addr_i,
  output logic [NUM_CH-1:0]               grant_o,
  output logic                            hit_o
);
  logic [NUM_CH-1:0] cand;
  logic unused_fetch_lo;

  assign unused_fetch_lo = ^fetch_addr_i[BLK_LOG2-1:0];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
    logic unused_ch_lo;
    assign unused_ch_lo = ^ch_addr_i[k][BLK_LOG2-1:0];
    assign cand[k] = corr_en_i && ch_en_i[k] &&
                     (fetch_addr_i[MATCH_AW-1:BLK_LOG2] == ch_addr_i[k][MATCH_AW-1:BLK_LOG2]);
  end

  // Isolate lowest set bit: lowest channel wins
  assign grant_o = cand & (~cand + NUM_CH'(1));
  assign hit_o   = |cand;

  assert_grant_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_gate_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !corr_en_i |-> (grant_o == '0));

  assert_hit_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $countones(grant_o) == 1);
endmodule

// File: rtl/rpu_subst.sv
module rpu_subst #(
  parameter int NUM_CH  = 4,
  parameter int PATCH_W = 64,
  parameter int BUS_W   = 32
) (
  input  logic [NUM_CH-1:0]                          grant_i,
  input  logic                                       hit_i,
  input  logic [$clog2(PATCH_W/BUS_W)-1:0]           word_sel_i,
  input  logic [NUM_CH-1:0][PATCH_W-1:0]             ch_data_i,
  input  logic [BUS_W-1:0]                           rom_data_i,
  output logic [BUS_W-1:0]                           data_o
);
  localparam int LANES     = BUS_W / 8;
  localparam int BLK_BYTES = PATCH_W / 8;

  logic [PATCH_W-1:0] patch;
  logic [BUS_W-1:0]   word;

  always_comb begin
    patch = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (grant_i[k]) patch = patch | ch_data_i[k];
    end
  end

  // Little-endian lanes: block byte b lives at patch[8b+7:8b]
  always_comb begin
    word = '0;
    for (int b = 0; b < LANES; b++) begin
      word[b*8 +: 8] = patch[((int'(word_sel_i) * LANES + b) % BLK_BYTES) * 8 +: 8];
    end
  end

  assign data_o = hit_i ? word : rom_data_i;
endmodule

// File: rtl/rom_patch_unit.sv
module rom_patch_unit
  import rpu_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int FETCH_AW = 32,
  parameter int MATCH_AW = 20,
  parameter int PATCH_W  = 64,
  parameter int BUS_W    = 32,
  parameter int REG_AW   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  input  logic [FETCH_AW-1:0] fetch_addr_i,
  input  logic [BUS_W-1:0]    rom_data_i,
  output logic [BUS_W-1:0]    fetch_data_o
);
  localparam int BLK_LOG2 = $clog2(PATCH_W / 8);
  localparam int WSEL_W   = $clog2(PATCH_W / BUS_W);

  logic                            corr_en;
  logic [NUM_CH-1:0]               ch_en;
  logic [NUM_CH-1:0][MATCH_AW-1:0] ch_addr;
  logic [NUM_CH-1:0][PATCH_W-1:0]  ch_data;
  logic [NUM_CH-1:0]               grant;
  logic                            hit;
  logic                            unused_fetch;

  assign unused_fetch = ^{fetch_addr_i[FETCH_AW-1:MATCH_AW],
                          fetch_addr_i[BLK_LOG2-WSEL_W-1:0]};

  rpu_regs #(
    .NUM_CH(NUM_CH), .MATCH_AW(MATCH_AW), .PATCH_W(PATCH_W), .REG_AW(REG_AW)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .corr_en_o   (corr_en),
    .ch_en_o     (ch_en),
    .ch_addr_o   (ch_addr),
    .ch_data_o   (ch_data)
  );

  rpu_match #(
    .NUM_CH(NUM_CH), .MATCH_AW(MATCH_AW), .BLK_LOG2(BLK_LOG2)
  ) u_match (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_addr_i (fetch_addr_i[MATCH_AW-1:0]),
    .corr_en_i    (corr_en),
    .ch_en_i      (ch_en),
    .ch_addr_i    (ch_addr),
    .grant_o      (grant),
    .hit_o        (hit)
  );

  rpu_subst #(
    .NUM_CH(NUM_CH), .PATCH_W(PATCH_W), .BUS_W(BUS_W)
  ) u_subst (
    .grant_i    (grant),
    .hit_i      (hit),
    .word_sel_i (fetch_addr_i[BLK_LOG2-1 -: WSEL_W]),
    .ch_data_i  (ch_data),
    .rom_data_i (rom_data_i),
    .data_o     (fetch_data_o)
  );

  assert_pass_raw_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (fetch_data_o == rom_data_i));

  assert_off_raw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !corr_en |-> (fetch_data_o == rom_data_i));
endmodule

// File: tb/rom_patch_unit_bench.sv
`timescale 1ns/1ps
module rom_patch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] fetch_addr = '0;
  logic [31:0] rom_data;
  logic [31:0] fetch_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] sh_ctrl;
  logic [31:0] sh_addr [4];
  logic [63:0] sh_data [4];

  always #10 clk = ~clk;

  function automatic logic [31:0] rom_fn(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  assign rom_data = rom_fn(fetch_addr);

  rom_patch_unit u_rom_patch_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .fetch_addr_i(fetch_addr),
    .rom_data_i(rom_data), .fetch_data_o(fetch_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    int k, o;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 8'h00) sh_ctrl = d & 32'h0000_000D;
    else if (sh_ctrl[0] && a >= 8'h40 && a < 8'h80) begin
      k = (int'(a) - 'h40) >> 4;
      o = int'(a) & 'hF;
      if (o == 0) sh_addr[k] = d & 32'h800F_FFFF;
      else if (o == 4) sh_data[k][31:0] = d;
      else if (o == 8) sh_data[k][63:32] = d;
    end
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #5 chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [31:0] exp_fetch(logic [31:0] fa);
    for (int k = 0; k < 4; k++) begin
      if (sh_ctrl[2] && sh_addr[k][31] && fa[19:3] == sh_addr[k][19:3])
        return fa[2] ? sh_data[k][63:32] : sh_data[k][31:0];
    end
    return rom_fn(fa);
  endfunction

  task automatic fetch(string tag, logic [31:0] fa, logic [31:0] exp);
    @(negedge clk);
    fetch_addr = fa;
    #5 chk(tag, fetch_data, exp);
  endtask

  // R7 R8 R9 R10: every word around each window, high bits varied
  task automatic sweep(string tag);
    logic [31:0] bases [3];
    logic [31:0] his [3];
    logic [31:0] fa;
    bases[0] = 32'h0000_2000; bases[1] = 32'h0000_A010; bases[2] = 32'h000F_FFF8;
    his[0] = 32'h0; his[1] = 32'h4000_0000; his[2] = 32'hFFF0_0000;
    for (int b = 0; b < 3; b++)
      for (int h = 0; h < 3; h++)
        for (int off = -16; off <= 20; off += 4) begin
          fa = his[h] | ((bases[b] + off) & 32'h000F_FFFF);
          fetch(tag, fa, exp_fetch(fa));
        end
  endtask

  initial begin
    sh_ctrl = '0;
    for (int k = 0; k < 4; k++) begin sh_addr[k] = '0; sh_data[k] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd("R1 ctrl reset", 8'h00, 32'h0);
    rd("R1 ch0 addr reset", 8'h40, 32'h0);
    rd("R1 ch3 data hi reset", 8'h78, 32'h0);
    fetch("R1 reset passthrough", 32'h4000_2000, rom_fn(32'h4000_2000));

    wr(8'h40, 32'h8000_2000);
    rd("R3 locked addr write", 8'h40, 32'h0);

    wr(8'h00, 32'hFFFF_FFFF);
    rd("R2 ctrl mask", 8'h00, 32'h0000_000D);
    wr(8'h00, 32'h0000_0001);
    rd("R2 ctrl open", 8'h00, 32'h0000_0001);

    wr(8'h40, 32'h8000_2000); wr(8'h44, 32'h3322_1100); wr(8'h48, 32'h7766_5544);
    wr(8'h50, 32'h8000_2005); wr(8'h54, 32'hDEAD_BEEF); wr(8'h58, 32'hCAFE_F00D);
    wr(8'h60, 32'h8000_A013); wr(8'h64, 32'h0123_4567); wr(8'h68, 32'h89AB_CDEF);
    wr(8'h70, 32'hFFFF_FFF8); wr(8'h74, 32'hA5A5_0001); wr(8'h78, 32'h5A5A_0002);

    rd("R4 ch0 addr", 8'h40, 32'h8000_2000);
    rd("R4 ch3 addr mask", 8'h70, 32'h800F_FFF8);
    rd("R5 ch1 data lo", 8'h54, 32'hDEAD_BEEF);
    rd("R5 ch2 data hi", 8'h68, 32'h89AB_CDEF);

    sweep("R6 correction off");

    wr(8'h00, 32'h0000_0004);
    rd("R2 ctrl active", 8'h00, 32'h0000_0004);
    rd("R5 readback while locked", 8'h48, 32'h7766_5544);

    fetch("R8 lanes 0..3", 32'h0000_2000, 32'h3322_1100);
    fetch("R8 lanes 4..7", 32'h0000_2004, 32'h7766_5544);
    fetch("R7 high bits ignored", 32'h8000_2004, 32'h7766_5544);
    fetch("R9 ch0 over ch1", 32'h0000_2000, 32'h3322_1100);
    fetch("R7 ch2 low bits ignored", 32'h0000_A010, 32'h0123_4567);
    fetch("R10 neighbour raw", 32'h0000_2008, rom_fn(32'h0000_2008));
    sweep("R7 R8 R9 R10 active");

    wr(8'h44, 32'h0000_0000);
    rd("R3 locked data write", 8'h44, 32'h3322_1100);
    fetch("R3 locked no effect", 32'h0000_2000, 32'h3322_1100);

    wr(8'h00, 32'h0000_0000);
    wr(8'h00, 32'h0000_0001);
    wr(8'h40, 32'h0000_2000);
    wr(8'h00, 32'h0000_0004);
    rd("R4 ch0 disabled", 8'h40, 32'h0000_2000);
    fetch("R6 R9 ch1 takes over", 32'h0000_2000, 32'hDEAD_BEEF);
    fetch("R6 R9 ch1 hi word", 32'h0000_2004, 32'hCAFE_F00D);
    sweep("R6 R9 after reprogram");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule